// File: doc/BRIEF.md
# Composable Large Binary Decoder Network

This block turns an N-bit binary code into a 2^N-bit one-hot vector, gated by an active-high enable. It has no flat case statement. The whole result is assembled from small K-input decoder leaves, and N must be a whole multiple of K. A compile-time parameter chooses how the leaves are wired together. In both cases the output is the same one-hot vector, so either wiring can be swapped in without touching the logic that reads it.

The coincident wiring works as follows:
- The code is split into R = N/K slices of K bits, and each slice gets its own leaf.
- Every output bit is an R-input AND that takes one line from each leaf.
- Only the leaf for the most significant slice sees the external enable. The other leaves are always enabled.

The tree wiring works as follows:
- The leaves are stacked in R levels.
- The top level decodes the most significant slice under the external enable.
- Each output line of a level enables one leaf of the level below it. That leaf decodes the next slice down.

The block is purely combinational and has no storage. Its data is a plain vector, not a stream, so it has no valid/ready handshake and no back-pressure. A consumer samples the output in the same cycle it drives the code.

Top module: `dec_network`

## Requirements
- R1: A leaf decoder with enable 1 and input value j drives its output bit j to 1 and every other output bit to 0.
- R2: A leaf decoder with enable 0 drives all of its output bits to 0, whatever its input.
- R3: In coincident wiring, output bit i equals the AND of high-leaf line t and low-leaf line s, where i = t·2^(N/2) + s. For example, with N=8 and K=4, code 36 raises output bit 36 (t=2, s=4) and leaves bit 37 at 0.
- R4: In coincident wiring, only the most significant leaf receives the external enable. With enable 0, the output is all zeros for every code.
- R5: In tree wiring, the line t of one level enables the leaf that drives the next level's outputs t·2^K through t·2^K+2^K−1. The final level therefore raises output bit equal to the code.
- R6: With enable 0, all 2^N output bits are 0 in both wirings, for every input code.
- R7: With enable 1, exactly one output bit is 1. Its position, counted from bit 0 as the least significant bit, equals the unsigned value of the input code.
- R8: For identical N, K, code and enable, the coincident and tree wirings produce bit-identical outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Active-high enable; 0 forces every output bit low |
| code | input | N | Unsigned binary code to decode |
| onehot | output | 2^N | One-hot result; bit i is high when code equals i and en is 1 |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies on any path from `en` or `code` to `onehot`. The bench drives a new code and enable just after a rising edge. It reads the outputs at the following falling edge, half a period later, by which time the combinational network has settled. The bench sweeps every code with enable low and with enable high for three sizes (N=6/K=3, N=8/K=4, N=12/K=4) in both wirings. For each vector it compares the output against an arithmetic shifted-one reference and against the other wiring.

// File: rtl/dec_net_pkg.sv
package dec_net_pkg;

  // Composition style of the decoder network.
  typedef enum logic [0:0] {
    STYLE_COINCIDENT = 1'b0,
    STYLE_TREE       = 1'b1
  } dec_style_e;

endpackage

// File: rtl/dec_leaf.sv
module dec_leaf #(
  parameter int K = 4
) (
  input  logic               en,
  input  logic [K-1:0]       sel,
  output logic [(1<<K)-1:0]  lines
);
  localparam int W = 1 << K;

  always_comb begin
    for (int j = 0; j < W; j++) begin
      lines[j] = en && (sel == K'(j));
    end
  end

  always_comb begin
    if (en) begin
      AST_LEAF_ONEHOT: assert ($onehot(lines) && lines[sel]) else $error("leaf one-hot broken"); // R1
    end else begin
      AST_LEAF_IDLE: assert (lines == '0) else $error("leaf active while disabled"); // R2
    end
  end
endmodule

// File: rtl/dec_coincident.sv
module dec_coincident #(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic               en,
  input  logic [N-1:0]       code,
  output logic [(1<<N)-1:0]  onehot
);
  localparam int R    = N / K;
  localparam int W    = 1 << K;
  localparam int OUTS = 1 << N;

  logic [W-1:0] slice_lines [R];

  // One leaf per K-bit slice; only the most significant slice sees en.
  for (genvar j = 0; j < R; j++) begin : g_leaf
    logic leaf_en;
    if (j == R - 1) begin : g_top
      assign leaf_en = en;
    end else begin : g_rest
      assign leaf_en = 1'b1;
    end
    dec_leaf #(.K(K)) u_leaf (
      .en    (leaf_en),
      .sel   (code[j*K +: K]),
      .lines (slice_lines[j])
    );
  end

  // One R-input AND per output: line of each slice picked by that slice of i.
  for (genvar i = 0; i < OUTS; i++) begin : g_and
    logic [R-1:0] terms;
    for (genvar j = 0; j < R; j++) begin : g_term
      localparam int PICK = (i >> (j*K)) % W;
      assign terms[j] = slice_lines[j][PICK];
    end
    assign onehot[i] = &terms;
  end

  always_comb begin
    if (!en) begin
      AST_COIN_GATED: assert (slice_lines[R-1] == '0 && onehot == '0) else $error("coincident enable leak"); // R4
    end
  end
endmodule

// File: rtl/dec_tree.sv
module dec_tree #(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic               en,
  input  logic [N-1:0]       code,
  output logic [(1<<N)-1:0]  onehot
);
  localparam int R = N / K;
  localparam int W = 1 << K;

  for (genvar l = 0; l < R; l++) begin : g_lvl
    localparam int NLEAF = 1 << (l*K);
    localparam int LW    = NLEAF * W;
    localparam int LSB   = (R - 1 - l) * K;
    logic [NLEAF-1:0] leaf_en;
    logic [LW-1:0]    outs;

    if (l == 0) begin : g_root
      assign leaf_en = en;
    end else begin : g_inner
      assign leaf_en = g_lvl[l-1].outs;
    end

    for (genvar m = 0; m < NLEAF; m++) begin : g_node
      dec_leaf #(.K(K)) u_leaf (
        .en    (leaf_en[m]),
        .sel   (code[LSB +: K]),
        .lines (outs[m*W +: W])
      );
    end

    always_comb begin
      AST_TREE_PATH: assert ($countones(outs) == $countones(leaf_en)) else $error("tree level fan-out broken"); // R5
    end
  end

  assign onehot = g_lvl[R-1].outs;
endmodule

// File: rtl/dec_network.sv
module dec_network
  import dec_net_pkg::*;
#(
  parameter int         N     = 8,
  parameter int         K     = 4,
  parameter dec_style_e STYLE = STYLE_COINCIDENT
) (
  input  logic               en,
  input  logic [N-1:0]       code,
  output logic [(1<<N)-1:0]  onehot
);
  if (K < 1 || N < K || (N % K) != 0) begin : g_bad_cfg
    $error("dec_network: N must be a positive multiple of K");
  end

  if (STYLE == STYLE_TREE) begin : g_tree
    dec_tree #(.N(N), .K(K)) u_core (
      .en     (en),
      .code   (code),
      .onehot (onehot)
    );
  end else begin : g_coin
    dec_coincident #(.N(N), .K(K)) u_core (
      .en     (en),
      .code   (code),
      .onehot (onehot)
    );
  end

  always_comb begin
    if (!en) begin
      AST_NET_IDLE: assert (onehot == '0) else $error("output active while disabled"); // R6
    end else begin
      AST_NET_ONEHOT: assert ($onehot(onehot)) else $error("output not one-hot"); // R7
      AST_NET_HIT: assert (onehot[code]) else $error("wrong output raised"); // R7
    end
  end
endmodule

// File: tb/dec_network_test.sv
module dec_network_test;
  import dec_net_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        en;
  logic [11:0] v;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0]   z6c,  z6t;
  logic [255:0]  z8c,  z8t;
  logic [4095:0] z12c, z12t;

  dec_network #(.N(8), .K(4), .STYLE(STYLE_COINCIDENT)) uut (
    .en(en), .code(v[7:0]), .onehot(z8c));
  dec_network #(.N(8), .K(4), .STYLE(STYLE_TREE)) uut_t8 (
    .en(en), .code(v[7:0]), .onehot(z8t));
  dec_network #(.N(6), .K(3), .STYLE(STYLE_COINCIDENT)) uut_c6 (
    .en(en), .code(v[5:0]), .onehot(z6c));
  dec_network #(.N(6), .K(3), .STYLE(STYLE_TREE)) uut_t6 (
    .en(en), .code(v[5:0]), .onehot(z6t));
  dec_network #(.N(12), .K(4), .STYLE(STYLE_COINCIDENT)) uut_c12 (
    .en(en), .code(v), .onehot(z12c));
  dec_network #(.N(12), .K(4), .STYLE(STYLE_TREE)) uut_t12 (
    .en(en), .code(v), .onehot(z12t));

  task automatic chk(input string what, input string req, input int x,
                     input logic [4095:0] got, input logic [4095:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s code=%0d en=%0b: got ones=%0d bit=%0b, expected ones=%0d bit=%0b",
               req, what, x, en, $countones(got), got[x], $countones(exp), exp[x]);
    end
  endtask

  function automatic logic [4095:0] ref_vec(input int x, input logic e);
    return e ? (4096'(1) << x) : '0;
  endfunction

  task automatic sweep_point(input int x);
    chk("N6 coincident",  en ? "R7" : "R6", x % 64,  4096'(z6c),  ref_vec(x % 64, en));
    chk("N6 tree",        en ? "R5" : "R6", x % 64,  4096'(z6t),  ref_vec(x % 64, en));
    chk("N8 coincident",  en ? "R3" : "R4", x % 256, 4096'(z8c),  ref_vec(x % 256, en));
    chk("N8 tree",        en ? "R5" : "R6", x % 256, 4096'(z8t),  ref_vec(x % 256, en));
    chk("N12 coincident", en ? "R1" : "R2", x,       z12c,        ref_vec(x, en));
    chk("N12 tree",       en ? "R7" : "R6", x,       z12t,        ref_vec(x, en));
    // R8: both wirings agree bit for bit
    chk("N8 tree vs coincident",  "R8", x % 256, 4096'(z8t),  4096'(z8c));
    chk("N12 tree vs coincident", "R8", x,       z12t,        z12c);
  endtask

  initial begin
    en = 1'b0;
    v  = '0;
    @(negedge clk);
    // reset-like idle state: disabled, code 0
    chk("N8 idle", "R6", 0, 4096'(z8c), '0);

    for (int e = 0; e < 2; e++) begin
      for (int x = 0; x < 4096; x++) begin
        @(posedge clk);
        en <= e[0];
        v  <= 12'(x);
        @(negedge clk);
        sweep_point(x);
      end
    end

    // R3: explicit coincident corner, code 36 -> line 2 of high leaf, line 4 of low leaf
    @(posedge clk);
    en <= 1'b1;
    v  <= 12'd36;
    @(negedge clk);
    checks++;
    if (z8c[36] !== 1'b1 || z8c[37] !== 1'b0 || z8c[4] !== 1'b0) begin
      errors++;
      $display("FAIL R3 code=36: got bit36=%0b bit37=%0b bit4=%0b, expected 1 0 0",
               z8c[36], z8c[37], z8c[4]);
    end

    // R4: disabling drops the output even with a code held
    @(posedge clk);
    en <= 1'b0;
    @(negedge clk);
    chk("N8 coincident hold code", "R4", 36, 4096'(z8c), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule